// File: doc/BRIEF.md
# I2C Slave Register Access Controller

This block is a serial-bus slave that lets an external host reach a bank of 128 byte-wide registers over a two-wire I2C bus. It watches the clock and data lines, which are synchronised into the system clock domain. It recognises start, repeated-start and stop conditions, and it answers only to one fixed 7-bit device address.

A transfer opens with the device address and a direction bit. A sub-address byte follows it. Bits [6:0] of the sub-address load a 7-bit register pointer. Bit 7 selects whether the pointer advances after every data byte. A write stores the bytes that follow the sub-address through a one-cycle write strobe on the register-file port. A read first sets the pointer in a write phase, then issues a repeated start with the direction bit set. The slave then shifts register contents out, most significant bit first, for as long as the host acknowledges each byte.

The slave pulls the data line low only through an open-drain pull output. It changes that output only while the clock line is low.

Top module: `i2cr_slave`

## Requirements
- R1: After reset `sda_pull` is 0 and `rf_we` is 0. A falling data line while the clock line is high (a START) puts the block into address reception with `sda_pull` at 0.
- R2: The first byte after a START is {7-bit address, direction bit}, sent MSB first. Direction 1 means read and 0 means write. When the address equals 7'b0011101, the block holds `sda_pull` at 1 through the high phase of the ninth clock.
- R3: A first byte with any other address gets no acknowledge. The block then leaves `sda_pull` at 0 and issues no `rf_we` until the next START.
- R4: In a write, the byte after the address is the sub-address. Bits [6:0] load the register pointer and bit 7 set to 1 enables pointer increment. The sub-address byte is acknowledged.
- R5: With increment enabled, each later write byte gives exactly one single-cycle `rf_we` pulse. `rf_addr` equals the pointer during the pulse, the pointer then advances by one, and each byte is acknowledged.
- R6: With increment disabled, every write byte goes to the same register.
- R7: After a repeated START and an address byte with direction 1, the block sends the register at the pointer MSB first. It drives `sda_pull` = 1 for a 0 bit and 0 for a 1 bit. While the host acknowledges (data low on the ninth clock), further bytes follow, and the pointer advances first when increment is enabled.
- R8: A not-acknowledge from the host (data high on the ninth clock) ends the read. `sda_pull` stays 0 for all later clocks until a new START.
- R9: The 7-bit pointer wraps from 127 to 0 when it increments in both reads and writes.
- R10: A STOP (rising data line while the clock line is high) or a START in the middle of a byte abandons that byte without any `rf_we`. STOP returns the block to idle and START returns it to address reception.
- R11: `sda_pull` changes value only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_pull | output | 1 | 1 = pull the data line low, 0 = release |
| rf_addr | output | 7 | Register index (current pointer) |
| rf_wdata | output | 8 | Byte to store |
| rf_we | output | 1 | Single-cycle write strobe |
| rf_rdata | input | 8 | Contents of the register at `rf_addr` |

## Verification
Both bus lines pass through a two-stage synchroniser and an edge register. As a result, `sda_pull` and `rf_we` react three system cycles after the bus edge that triggers them. An acknowledge rises three cycles after the eighth clock falls and drops three cycles after the ninth clock falls. A data bit is presented three cycles after the previous clock fall. The bench holds each bus half-phase for at least four system cycles. It samples `sda_pull` four cycles into each high phase, when every such change has settled. It counts stored bytes in its own register model at the strobe edge. A monitor flags any change of `sda_pull` seen while the clock line is high.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int DATA_W = 8;
    localparam int REG_AW = 7;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_MACK
    } st_e;

    // what follows the acknowledge slot
    typedef enum logic [1:0] {
        AF_SUB,
        AF_DAT,
        AF_WR,
        AF_RD
    } af_e;

    function automatic logic bit_at(input logic [DATA_W-1:0] b,
                                    input logic [CNT_W-1:0]  idx);
        return b[DATA_W - 1 - int'(idx)];
    endfunction

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) pipe <= '1;
                else     pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cr_busmon.sv
module i2cr_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_s;
    logic scl_p, sda_p;

    i2cr_sync #(.STAGES(SYNC_STAGES)) u_scl (.clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
    i2cr_sync #(.STAGES(SYNC_STAGES)) u_sda (.clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
    import i2cr_pkg::*;
#(
    parameter logic [REG_AW-1:0] DEV_ADDR = 7'b0011101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_c,
    input  logic              stop_c,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              sda_pull,
    output logic [REG_AW-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    output st_e               st
);
    af_e               after;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rx, tx;
    logic [REG_AW-1:0] ptr;
    logic              inc, mack_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            after    <= AF_SUB;
            cnt      <= '0;
            rx       <= '0;
            tx       <= '0;
            ptr      <= '0;
            inc      <= 1'b0;
            mack_ok  <= 1'b0;
            sda_pull <= 1'b0;
            rf_we    <= 1'b0;
            rf_wdata <= '0;
        end else begin
            rf_we <= 1'b0;
            if (stop_c) begin
                st       <= ST_IDLE;
                sda_pull <= 1'b0;
                cnt      <= '0;
            end else if (start_c) begin
                st       <= ST_ADDR;
                sda_pull <= 1'b0;
                cnt      <= '0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (scl_rise && cnt != BYTE_DONE) begin
                            rx  <= {rx[DATA_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == BYTE_DONE) begin
                            cnt <= '0;
                            if (st == ST_ADDR) begin
                                if (rx[DATA_W-1:1] == DEV_ADDR) begin
                                    st       <= ST_ACK;
                                    sda_pull <= 1'b1;
                                    after    <= rx[0] ? AF_RD : AF_SUB;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_SUB) begin
                                ptr      <= rx[REG_AW-1:0];
                                inc      <= rx[DATA_W-1];
                                st       <= ST_ACK;
                                sda_pull <= 1'b1;
                                after    <= AF_DAT;
                            end else begin
                                rf_we    <= 1'b1;
                                rf_wdata <= rx;
                                st       <= ST_ACK;
                                sda_pull <= 1'b1;
                                after    <= AF_WR;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            cnt      <= '0;
                            unique case (after)
                                AF_SUB: st <= ST_SUB;
                                AF_DAT: st <= ST_WDATA;
                                AF_WR: begin
                                    st <= ST_WDATA;
                                    if (inc) ptr <= ptr + 1'b1;
                                end
                                AF_RD: begin
                                    st       <= ST_RDATA;
                                    tx       <= rf_rdata;
                                    sda_pull <= ~rf_rdata[DATA_W-1];
                                end
                            endcase
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == BYTE_DONE) begin
                                sda_pull <= 1'b0;
                                st       <= ST_MACK;
                                cnt      <= '0;
                            end else begin
                                sda_pull <= ~bit_at(tx, cnt);
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_s;
                            if (!sda_s && inc) ptr <= ptr + 1'b1;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                st       <= ST_RDATA;
                                tx       <= rf_rdata;
                                sda_pull <= ~rf_rdata[DATA_W-1];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rf_addr = ptr;
endmodule

// File: rtl/i2cr_slave.sv
module i2cr_slave
    import i2cr_pkg::*;
#(
    parameter logic [REG_AW-1:0] DEV_ADDR    = 7'b0011101,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull,
    output logic [REG_AW-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              rf_we,
    input  logic [DATA_W-1:0] rf_rdata
);
    logic sda_s, scl_rise, scl_fall, start_c, stop_c;
    st_e  st;

    i2cr_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    i2cr_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
        .rf_rdata(rf_rdata), .sda_pull(sda_pull), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_we(rf_we), .st(st)
    );
endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk
    import i2cr_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_pull,
    input logic rf_we,
    input logic start_c,
    input logic stop_c,
    input st_e  st
);
    // R11
    pull_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_pull != $past(sda_pull)) |-> !scl_i);

    // R1
    start_entry_chk: assert property (@(posedge clk) disable iff (rst)
        start_c |=> (st == ST_ADDR) && !sda_pull);

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_c |=> (st == ST_IDLE) && !sda_pull && !rf_we);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_pull && !rf_we);

    // R5
    we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);

    // R2
    ack_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK) |-> sda_pull);
endmodule

bind i2cr_slave i2cr_chk u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull(sda_pull),
    .rf_we(rf_we), .start_c(start_c), .stop_c(stop_c), .st(st)
);

// File: tb/sim_i2cr_slave.sv
`timescale 1ns/1ps
module sim_i2cr_slave;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_pull;
    logic [6:0] rf_addr;
    logic [7:0] rf_wdata;
    logic       rf_we;
    logic [7:0] rf_rdata;

    logic [7:0] mem [128];
    int         wr_cnt;
    int         vectors = 0;
    int         miscompares = 0;
    int         edge_viol = 0;
    logic       prev_pull = 1'b0;
    logic       done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;
    assign rf_rdata = mem[rf_addr];

    i2cr_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sda_pull(sda_pull), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .rf_we(rf_we), .rf_rdata(rf_rdata)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 5 + 3);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
            wr_cnt <= 0;
        end else if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
            wr_cnt       <= wr_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && sda_pull != prev_pull && scl) edge_viol++;
        prev_pull = sda_pull;
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        scl = 1'b0; wt(4);
        m_sda = 1'b1; wt(4);
        scl = 1'b1; wt(4);
        m_sda = 1'b0; wt(4);
        scl = 1'b0; wt(4);
    endtask

    task automatic bus_stop;
        scl = 1'b0; wt(4);
        m_sda = 1'b0; wt(4);
        scl = 1'b1; wt(4);
        m_sda = 1'b1; wt(4);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            scl = 1'b0; wt(4);
            m_sda = b[7-i]; wt(4);
            scl = 1'b1; wt(8);
        end
        scl = 1'b0;
    endtask

    task automatic ack_slot(output logic ack);
        scl = 1'b0; wt(4);
        m_sda = 1'b1; wt(4);
        scl = 1'b1; wt(4);
        ack = sda_pull; wt(4);
        scl = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] b, input string tag, input logic exp_ack);
        logic a;
        send_bits(b, 8);
        ack_slot(a);
        check(tag, int'(a), int'(exp_ack));
    endtask

    task automatic rd_byte(output logic [7:0] b, input logic nack);
        for (int i = 0; i < 8; i++) begin
            scl = 1'b0; wt(4);
            m_sda = 1'b1; wt(4);
            scl = 1'b1; wt(4);
            b[7-i] = ~sda_pull; wt(4);
        end
        scl = 1'b0; wt(4);
        m_sda = nack; wt(4);
        scl = 1'b1; wt(4);
        check("R7 pull released in host ack slot", int'(sda_pull), 0);
        wt(4);
        scl = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset sda_pull", int'(sda_pull), 0);
        check("R1 reset rf_we", int'(rf_we), 0);
    endtask

    task automatic t_write_inc;
        int w0;
        w0 = wr_cnt;
        bus_start;
        check("R1 no pull after start", int'(sda_pull), 0);
        wr_byte(8'h3A, "R2 address ack (write)", 1'b1);
        wr_byte(8'h85, "R4 sub-address ack", 1'b1);
        wr_byte(8'hA1, "R5 data ack 0", 1'b1);
        wr_byte(8'hB2, "R5 data ack 1", 1'b1);
        wr_byte(8'hC3, "R5 data ack 2", 1'b1);
        bus_stop;
        check("R5 reg5", int'(mem[5]), 'hA1);
        check("R5 reg6", int'(mem[6]), 'hB2);
        check("R5 reg7", int'(mem[7]), 'hC3);
        check("R5 write count", wr_cnt - w0, 3);
    endtask

    task automatic t_write_same;
        bus_start;
        wr_byte(8'h3A, "R2 address ack", 1'b1);
        wr_byte(8'h10, "R4 sub-address ack no-inc", 1'b1);
        wr_byte(8'h11, "R6 data ack 0", 1'b1);
        wr_byte(8'h22, "R6 data ack 1", 1'b1);
        wr_byte(8'h33, "R6 data ack 2", 1'b1);
        bus_stop;
        check("R6 reg 0x10 holds last", int'(mem[16]), 'h33);
        check("R6 reg 0x11 untouched", int'(mem[17]), int'(init_val(17)));
    endtask

    task automatic t_bad_addr;
        int w0;
        w0 = wr_cnt;
        bus_start;
        wr_byte(8'h3C, "R3 foreign address not acked", 1'b0);
        wr_byte(8'h81, "R3 following byte not acked", 1'b0);
        wr_byte(8'h55, "R3 third byte not acked", 1'b0);
        bus_stop;
        check("R3 no write on foreign address", wr_cnt - w0, 0);
        bus_start;
        wr_byte(8'h3B, "R3 foreign-free read address acked", 1'b1);
        begin
            logic [7:0] d;
            rd_byte(d, 1'b1);
        end
        bus_stop;
    endtask

    task automatic t_read_inc;
        logic [7:0] d;
        bus_start;
        wr_byte(8'h3A, "R7 address ack (pointer set)", 1'b1);
        wr_byte(8'h85, "R7 sub-address ack", 1'b1);
        bus_start;
        wr_byte(8'h3B, "R2 address ack (read)", 1'b1);
        rd_byte(d, 1'b0); check("R7 read reg5", int'(d), 'hA1);
        rd_byte(d, 1'b0); check("R7 read reg6", int'(d), 'hB2);
        rd_byte(d, 1'b1); check("R7 read reg7", int'(d), 'hC3);
        rd_byte(d, 1'b1);
        check("R8 no drive after host nack", int'(d), 'hFF);
        bus_stop;
    endtask

    task automatic t_read_same;
        logic [7:0] d;
        bus_start;
        wr_byte(8'h3A, "R2 address ack", 1'b1);
        wr_byte(8'h10, "R4 sub-address ack", 1'b1);
        bus_start;
        wr_byte(8'h3B, "R2 read address ack", 1'b1);
        rd_byte(d, 1'b0); check("R7 no-inc read 0", int'(d), 'h33);
        rd_byte(d, 1'b1); check("R7 no-inc read 1", int'(d), 'h33);
        bus_stop;
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        bus_start;
        wr_byte(8'h3A, "R2 address ack", 1'b1);
        wr_byte(8'hFF, "R4 sub-address 127 inc", 1'b1);
        wr_byte(8'h77, "R9 data ack 127", 1'b1);
        wr_byte(8'h88, "R9 data ack wrap", 1'b1);
        bus_stop;
        check("R9 reg127 write", int'(mem[127]), 'h77);
        check("R9 reg0 after wrap", int'(mem[0]), 'h88);
        bus_start;
        wr_byte(8'h3A, "R2 address ack", 1'b1);
        wr_byte(8'hFF, "R4 sub-address ack", 1'b1);
        bus_start;
        wr_byte(8'h3B, "R2 read address ack", 1'b1);
        rd_byte(d, 1'b0); check("R9 read reg127", int'(d), 'h77);
        rd_byte(d, 1'b1); check("R9 read wraps to reg0", int'(d), 'h88);
        bus_stop;
    endtask

    task automatic t_abort;
        int w0;
        w0 = wr_cnt;
        bus_start;
        wr_byte(8'h3A, "R2 address ack", 1'b1);
        wr_byte(8'h20, "R4 sub-address ack", 1'b1);
        send_bits(8'hEE, 4);
        bus_stop;
        check("R10 stop mid-byte no write", wr_cnt - w0, 0);
        check("R10 reg 0x20 untouched", int'(mem[32]), int'(init_val(32)));
        check("R10 released after stop", int'(sda_pull), 0);
        bus_start;
        wr_byte(8'h3A, "R2 address ack", 1'b1);
        wr_byte(8'h21, "R4 sub-address ack", 1'b1);
        send_bits(8'h99, 5);
        bus_start;
        wr_byte(8'h3A, "R10 address ack after restart", 1'b1);
        wr_byte(8'h22, "R4 sub-address ack", 1'b1);
        wr_byte(8'h44, "R5 data ack", 1'b1);
        bus_stop;
        check("R10 reg 0x21 untouched", int'(mem[33]), int'(init_val(33)));
        check("R10 reg 0x22 written", int'(mem[34]), 'h44);
        check("R10 one write only", wr_cnt - w0, 1);
    endtask

    task automatic t_edge_rule;
        check("R11 sda_pull changed with clock high", edge_viol, 0);
    endtask

    initial begin
        wt(5);
        rst = 1'b0;
        wt(5);
        t_reset;
        t_write_inc;
        t_write_same;
        t_bad_addr;
        t_read_inc;
        t_read_same;
        t_wrap;
        t_abort;
        t_edge_rule;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule